// File: doc/BRIEF.md
# Packed and Unpacked BCD Adjuster

This unit applies the decimal-correction step that follows or precedes byte arithmetic on a two-byte accumulator: a high byte and a low byte. One operation is accepted per valid/ready handshake. The unit corrects the low byte (and, where the operation calls for it, the high byte) and produces the carry, auxiliary-carry, zero, sign and parity flags. The result is registered and appears one clock after acceptance.

Six corrections are supported. Two of them adjust single-digit (unpacked) results after an add or a subtract. Two adjust two-digit (packed) results after an add or a subtract. The fifth folds two digits into one binary byte before a divide, and the sixth splits a binary byte into two digits after a multiply. The last two take an 8-bit base from an immediate input. A zero base on the split operation raises a divide-fault strobe instead of producing a result.

A flag that an operation does not define keeps its prior value. For carry and auxiliary carry the prior value is the incoming flag. For zero, sign and parity it is the value last presented at the output. Instruction decode and memory access belong to the surrounding core.

Top module: `bcd_adjust_unit`

## Requirements
- R1: Operation code 0 (unpacked add): if the low-byte low nibble exceeds 9 or the incoming auxiliary flag is 1, 6 is added to the low byte, the high byte is incremented, and carry and auxiliary are both set. Otherwise both are cleared. The low byte is then masked to its low nibble, and zero, sign and parity keep their prior values.
- R2: Operation code 1 (unpacked subtract) uses the same condition and flag rule as R1, but subtracts 6 from the low byte and decrements the high byte, wrapping modulo 256. The low byte is then masked to its low nibble.
- R3: Operation code 2 (packed add) works from the original low byte L and the original carry C. If L's low nibble exceeds 9 or the auxiliary flag is 1, 6 is added and auxiliary is set; otherwise auxiliary is cleared. If L > 0x99 or C is 1, 0x60 is added and carry is set; otherwise carry is cleared. The high byte is unchanged.
- R4: Operation code 3 (packed subtract) follows R3 with 6 and 0x60 subtracted instead of added. The conditions are evaluated on the original low byte and the original carry.
- R5: Operation code 4 (divide preparation) sets the low byte to (low + high × base) mod 256 and clears the high byte. Carry and auxiliary pass through unchanged.
- R6: Operation code 5 (multiply split) with a nonzero base sets the high byte to low / base and the low byte to low mod base. Carry and auxiliary pass through unchanged.
- R7: Operation code 5 with a base of 0 asserts div_fault with the result. Both bytes and carry and auxiliary are returned unchanged, and zero, sign and parity keep their prior values.
- R8: For operation codes 2 to 5, zero is set when the final low byte is 0, sign equals bit 7 of the final low byte, and parity is set when the final low byte has an even number of ones.
- R9: A result stays presented, unchanged, while out_valid is 1 and out_ready is 0, and no new operation is accepted during that time. A new operation may be accepted in the same cycle in which the pending result is taken.
- R10: Operation codes 6 and 7 return both bytes and carry and auxiliary unchanged, keep zero, sign and parity, and do not raise div_fault.
- R11: After reset, out_valid, div_fault and all five output flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| op | input | 3 | Operation code (0 to 5 defined, 6 and 7 pass through) |
| ah_in | input | 8 | High accumulator byte |
| al_in | input | 8 | Low accumulator byte |
| imm | input | 8 | Base for divide preparation and multiply split |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| ah_out | output | 8 | Resulting high byte |
| al_out | output | 8 | Resulting low byte |
| cf_out | output | 1 | Carry flag |
| af_out | output | 1 | Auxiliary-carry flag |
| zf_out | output | 1 | Zero flag |
| sf_out | output | 1 | Sign flag |
| pf_out | output | 1 | Parity flag (even number of ones) |
| div_fault | output | 1 | Zero base on multiply split |

## Verification
Two events can share one cycle: handing over a pending result and accepting the next operation. The bench stalls the consumer so that a packed-add result is held while a second operation waits at the input. It checks that the held bytes do not move and that in_ready stays low. It then raises out_ready and expects the second operation's result, not a repeat of the first, on the very next cycle. A zero-base fault that follows a packed adjust is also checked to confirm that the zero, sign and parity values from the earlier result survive.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_UADD  = 3'd0,
        OP_USUB  = 3'd1,
        OP_PADD  = 3'd2,
        OP_PSUB  = 3'd3,
        OP_PREP  = 3'd4,
        OP_SPLIT = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } adj_op_e;

    // Output of one correction path before flag finishing
    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic              cf;
        logic              af;
        logic              arith;  // zero/sign/parity follow lo
        logic              fault;
    } path_res_t;

    // Registered state of the unit
    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic              cf;
        logic              af;
        logic              zf;
        logic              sf;
        logic              pf;
        logic              fault;
    } unit_state_t;

    function automatic logic even_ones(input logic [BYTE_W-1:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/bcd_unpacked_path.sv
module bcd_unpacked_path
    import bcd_adj_pkg::*;
#(
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic              af_i,
    output path_res_t         res_o
);
    localparam logic [BYTE_W-1:0] DIGIT_FIX = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] LOW_MASK  = BYTE_W'(15);

    logic              need_fix;
    logic [BYTE_W-1:0] lo_fixed;
    logic [BYTE_W-1:0] hi_fixed;

    always_comb begin
        need_fix = (lo_i[3:0] > 4'd9) || af_i;
        if (SUBTRACT) begin
            lo_fixed = lo_i - DIGIT_FIX;
            hi_fixed = hi_i - BYTE_W'(1);
        end else begin
            lo_fixed = lo_i + DIGIT_FIX;
            hi_fixed = hi_i + BYTE_W'(1);
        end
        res_o       = '0;
        res_o.hi    = need_fix ? hi_fixed : hi_i;
        res_o.lo    = (need_fix ? lo_fixed : lo_i) & LOW_MASK;
        res_o.cf    = need_fix;
        res_o.af    = need_fix;
        res_o.arith = 1'b0;
        res_o.fault = 1'b0;
    end
endmodule

// File: rtl/bcd_packed_path.sv
module bcd_packed_path
    import bcd_adj_pkg::*;
#(
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic              cf_i,
    input  logic              af_i,
    output path_res_t         res_o
);
    localparam logic [BYTE_W-1:0] LOW_FIX  = BYTE_W'(8'h06);
    localparam logic [BYTE_W-1:0] HIGH_FIX = BYTE_W'(8'h60);
    localparam logic [BYTE_W-1:0] HIGH_LIM = BYTE_W'(8'h99);

    logic              low_step;
    logic              high_step;
    logic [BYTE_W-1:0] stage1;
    logic [BYTE_W-1:0] stage2;

    always_comb begin
        // Both decisions use the original byte and carry
        low_step  = (lo_i[3:0] > 4'd9) || af_i;
        high_step = (lo_i > HIGH_LIM) || cf_i;
        if (SUBTRACT) begin
            stage1 = low_step  ? lo_i - LOW_FIX    : lo_i;
            stage2 = high_step ? stage1 - HIGH_FIX : stage1;
        end else begin
            stage1 = low_step  ? lo_i + LOW_FIX    : lo_i;
            stage2 = high_step ? stage1 + HIGH_FIX : stage1;
        end
        res_o       = '0;
        res_o.hi    = hi_i;
        res_o.lo    = stage2;
        res_o.af    = low_step;
        res_o.cf    = high_step;
        res_o.arith = 1'b1;
        res_o.fault = 1'b0;
    end
endmodule

// File: rtl/bcd_scale_path.sv
module bcd_scale_path
    import bcd_adj_pkg::*;
(
    input  logic              split_i,  // 1: split after multiply, 0: fold before divide
    input  logic [BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] base_i,
    input  logic              cf_i,
    input  logic              af_i,
    output path_res_t         res_o
);
    localparam int PROD_W = 2 * BYTE_W;

    logic [PROD_W-1:0] prod;
    logic [BYTE_W-1:0] safe_base;
    logic              zero_base;

    always_comb begin
        prod      = PROD_W'(hi_i) * PROD_W'(base_i);
        zero_base = (base_i == '0);
        safe_base = zero_base ? BYTE_W'(1) : base_i;
        res_o     = '0;
        res_o.cf  = cf_i;
        res_o.af  = af_i;
        if (!split_i) begin
            res_o.hi    = '0;
            res_o.lo    = lo_i + prod[BYTE_W-1:0];
            res_o.arith = 1'b1;
        end else if (zero_base) begin
            res_o.hi    = hi_i;
            res_o.lo    = lo_i;
            res_o.arith = 1'b0;
            res_o.fault = 1'b1;
        end else begin
            res_o.hi    = lo_i / safe_base;
            res_o.lo    = lo_i % safe_base;
            res_o.arith = 1'b1;
        end
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
    import bcd_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   op,
    input  logic [BYTE_W-1:0] ah_in,
    input  logic [BYTE_W-1:0] al_in,
    input  logic [BYTE_W-1:0] imm,
    input  logic              cf_in,
    input  logic              af_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] ah_out,
    output logic [BYTE_W-1:0] al_out,
    output logic              cf_out,
    output logic              af_out,
    output logic              zf_out,
    output logic              sf_out,
    output logic              pf_out,
    output logic              div_fault
);
    localparam int N_DIR = 2;  // add and subtract variants

    unit_state_t st_d, st_q;
    path_res_t   unp_res [N_DIR];
    path_res_t   pkd_res [N_DIR];
    path_res_t   scl_res;
    path_res_t   sel_res;
    adj_op_e     op_sel;

    genvar g;
    generate
        for (g = 0; g < N_DIR; g++) begin : g_dir
            bcd_unpacked_path #(.SUBTRACT(g == 1)) u_unp (
                .hi_i (ah_in),
                .lo_i (al_in),
                .af_i (af_in),
                .res_o(unp_res[g])
            );
            bcd_packed_path #(.SUBTRACT(g == 1)) u_pkd (
                .hi_i (ah_in),
                .lo_i (al_in),
                .cf_i (cf_in),
                .af_i (af_in),
                .res_o(pkd_res[g])
            );
        end
    endgenerate

    bcd_scale_path u_scl (
        .split_i(op_sel == OP_SPLIT),
        .hi_i   (ah_in),
        .lo_i   (al_in),
        .base_i (imm),
        .cf_i   (cf_in),
        .af_i   (af_in),
        .res_o  (scl_res)
    );

    assign op_sel   = adj_op_e'(op);
    assign in_ready = !st_q.valid || out_ready;

    always_comb begin
        sel_res    = '0;
        sel_res.hi = ah_in;
        sel_res.lo = al_in;
        sel_res.cf = cf_in;
        sel_res.af = af_in;
        case (op_sel)
            OP_UADD:           sel_res = unp_res[0];
            OP_USUB:           sel_res = unp_res[1];
            OP_PADD:           sel_res = pkd_res[0];
            OP_PSUB:           sel_res = pkd_res[1];
            OP_PREP, OP_SPLIT: sel_res = scl_res;
            default:           ;
        endcase

        st_d = st_q;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
        if (in_valid && in_ready) begin
            st_d.valid = 1'b1;
            st_d.hi    = sel_res.hi;
            st_d.lo    = sel_res.lo;
            st_d.cf    = sel_res.cf;
            st_d.af    = sel_res.af;
            st_d.fault = sel_res.fault;
            if (sel_res.arith) begin
                st_d.zf = (sel_res.lo == '0);
                st_d.sf = sel_res.lo[BYTE_W-1];
                st_d.pf = even_ones(sel_res.lo);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign ah_out    = st_q.hi;
    assign al_out    = st_q.lo;
    assign cf_out    = st_q.cf;
    assign af_out    = st_q.af;
    assign zf_out    = st_q.zf;
    assign sf_out    = st_q.sf;
    assign pf_out    = st_q.pf;
    assign div_fault = st_q.fault && st_q.valid;

endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk
    import bcd_adj_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [OP_W-1:0]   op,
    input logic [BYTE_W-1:0] ah_in,
    input logic [BYTE_W-1:0] al_in,
    input logic [BYTE_W-1:0] imm,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] ah_out,
    input logic [BYTE_W-1:0] al_out,
    input logic              zf_out,
    input logic              div_fault
);
    logic take;
    assign take = in_valid && in_ready;

    assert_unpacked_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take && (op == 3'd0 || op == 3'd1) |=> al_out[7:4] == 4'h0);

    assert_packed_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take && (op == 3'd2 || op == 3'd3) |=> zf_out == (al_out == '0));

    assert_prep_clears_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take && op == 3'd4 |=> ah_out == '0 && !div_fault);

    assert_fault_keeps_bytes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take && op == 3'd5 && imm == '0 |=>
        div_fault && ah_out == $past(ah_in) && al_out == $past(al_in));

    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(ah_out) && $stable(al_out));

    assert_fault_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_fault |-> out_valid);

endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .op       (op),
    .ah_in    (ah_in),
    .al_in    (al_in),
    .imm      (imm),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .ah_out   (ah_out),
    .al_out   (al_out),
    .zf_out   (zf_out),
    .div_fault(div_fault)
);

// File: tb/bcd_adjust_unit_tb.sv
`timescale 1ns/1ps
module bcd_adjust_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, out_valid, out_ready;
    logic [2:0] op;
    logic [7:0] ah_in, al_in, imm, ah_out, al_out;
    logic       cf_in, af_in, cf_out, af_out, zf_out, sf_out, pf_out, div_fault;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    bcd_adjust_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op(op), .ah_in(ah_in), .al_in(al_in), .imm(imm),
        .cf_in(cf_in), .af_in(af_in), .out_valid(out_valid), .out_ready(out_ready),
        .ah_out(ah_out), .al_out(al_out), .cf_out(cf_out), .af_out(af_out),
        .zf_out(zf_out), .sf_out(sf_out), .pf_out(pf_out), .div_fault(div_fault)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    // flags packed as {cf,af,zf,sf,pf}
    function automatic logic [7:0] flags();
        return {3'b000, cf_out, af_out, zf_out, sf_out, pf_out};
    endfunction

    // Offer one operation at a falling edge, sample the result one edge later
    task automatic run_op(input logic [2:0] o, input logic [7:0] h, input logic [7:0] l,
                          input logic [7:0] b, input logic c, input logic a);
        @(negedge clk);
        op = o; ah_in = h; al_in = l; imm = b; cf_in = c; af_in = a;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [7:0] h, input logic [7:0] l,
                              input logic [7:0] f, input logic flt);
        check({req, " valid"}, {7'd0, out_valid}, 8'h01);
        check({req, " hi"}, ah_out, h);
        check({req, " lo"}, al_out, l);
        check({req, " flags"}, flags(), f);
        check({req, " fault"}, {7'd0, div_fault}, {7'd0, flt});
    endtask

    task automatic t_reset_r11();
        check("R11 valid", {7'd0, out_valid}, 8'h00);
        check("R11 fault", {7'd0, div_fault}, 8'h00);
        check("R11 flags", flags(), 8'h00);
    endtask

    task automatic t_uadd_r1();
        run_op(3'd0, 8'h01, 8'h0B, 8'h00, 1'b0, 1'b0);
        expect_out("R1 nibble>9", 8'h02, 8'h01, 8'b11000, 1'b0);
        run_op(3'd0, 8'h03, 8'h35, 8'h00, 1'b1, 1'b0);
        expect_out("R1 no fix", 8'h03, 8'h05, 8'b00000, 1'b0);
        run_op(3'd0, 8'h04, 8'h12, 8'h00, 1'b0, 1'b1);
        expect_out("R1 af in", 8'h05, 8'h08, 8'b11000, 1'b0);
    endtask

    task automatic t_usub_r2();
        run_op(3'd1, 8'h02, 8'h0F, 8'h00, 1'b0, 1'b0);
        expect_out("R2 fix", 8'h01, 8'h09, 8'b11000, 1'b0);
        run_op(3'd1, 8'h00, 8'h0C, 8'h00, 1'b0, 1'b0);
        expect_out("R2 wrap", 8'hFF, 8'h06, 8'b11000, 1'b0);
    endtask

    task automatic t_padd_r3();
        run_op(3'd2, 8'h77, 8'h9A, 8'h00, 1'b0, 1'b0);
        expect_out("R3 both steps", 8'h77, 8'h00, 8'b11101, 1'b0);
        run_op(3'd2, 8'h00, 8'h15, 8'h00, 1'b0, 1'b0);
        expect_out("R3 none", 8'h00, 8'h15, 8'b00000, 1'b0);
        run_op(3'd2, 8'h00, 8'h45, 8'h00, 1'b1, 1'b0);
        expect_out("R3 carry in", 8'h00, 8'hA5, 8'b10011, 1'b0);
    endtask

    task automatic t_psub_r4();
        run_op(3'd3, 8'h00, 8'h2B, 8'h00, 1'b0, 1'b0);
        expect_out("R4 low", 8'h00, 8'h25, 8'b01000, 1'b0);
        run_op(3'd3, 8'h00, 8'h03, 8'h00, 1'b0, 1'b1);
        expect_out("R4 low borrow", 8'h00, 8'hFD, 8'b01010, 1'b0);
        run_op(3'd3, 8'h00, 8'hA0, 8'h00, 1'b0, 1'b0);
        expect_out("R4 high", 8'h00, 8'h40, 8'b10000, 1'b0);
    endtask

    task automatic t_prep_r5();
        run_op(3'd4, 8'h07, 8'h05, 8'd10, 1'b1, 1'b0);
        expect_out("R5 fold", 8'h00, 8'h4B, 8'b10001, 1'b0);
        run_op(3'd4, 8'h30, 8'h10, 8'd10, 1'b0, 1'b1);
        expect_out("R5 wrap R8", 8'h00, 8'hF0, 8'b01011, 1'b0);
    endtask

    task automatic t_split_r6();
        run_op(3'd5, 8'hEE, 8'h4B, 8'd10, 1'b0, 1'b0);
        expect_out("R6 split", 8'h07, 8'h05, 8'b00001, 1'b0);
        run_op(3'd5, 8'h12, 8'h00, 8'd10, 1'b0, 1'b0);
        expect_out("R6 zero R8", 8'h00, 8'h00, 8'b00101, 1'b0);
        run_op(3'd5, 8'h00, 8'd100, 8'd7, 1'b1, 1'b1);
        expect_out("R6 base7", 8'h0E, 8'h02, 8'b11000, 1'b0);
    endtask

    // Packed add sets zf/sf/pf, then the fault and reserved codes must keep them
    task automatic t_fault_r7_r10();
        run_op(3'd2, 8'h00, 8'h9A, 8'h00, 1'b0, 1'b0);
        expect_out("R7 setup", 8'h00, 8'h00, 8'b11101, 1'b0);
        run_op(3'd5, 8'h12, 8'h34, 8'h00, 1'b1, 1'b1);
        expect_out("R7 zero base", 8'h12, 8'h34, 8'b11101, 1'b1);
        run_op(3'd0, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0);
        expect_out("R1 zsp held", 8'h00, 8'h01, 8'b00101, 1'b0);
        run_op(3'd6, 8'h11, 8'h22, 8'h09, 1'b1, 1'b0);
        expect_out("R10 code6", 8'h11, 8'h22, 8'b10101, 1'b0);
        run_op(3'd7, 8'h33, 8'h0F, 8'h00, 1'b0, 1'b1);
        expect_out("R10 code7", 8'h33, 8'h0F, 8'b01101, 1'b0);
    endtask

    task automatic t_stall_r9();
        @(negedge clk);
        out_ready = 1'b0;
        op = 3'd2; ah_in = 8'h00; al_in = 8'h45; imm = 8'h00; cf_in = 1'b1; af_in = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        op = 3'd4; ah_in = 8'h07; al_in = 8'h05; imm = 8'd10; cf_in = 1'b0; af_in = 1'b0;
        @(negedge clk);
        check("R9 stalled not ready", {7'd0, in_ready}, 8'h00);
        expect_out("R9 held", 8'h00, 8'hA5, 8'b10011, 1'b0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        expect_out("R9 next taken", 8'h00, 8'h4B, 8'b00001, 1'b0);
        @(negedge clk);
        check("R9 drained", {7'd0, out_valid}, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        op = '0; ah_in = '0; al_in = '0; imm = '0; cf_in = 1'b0; af_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_r11();
        t_uadd_r1();
        t_usub_r2();
        t_padd_r3();
        t_psub_r4();
        t_prep_r5();
        t_split_r6();
        t_fault_r7_r10();
        t_stall_r9();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule